// File: doc/BRIEF.md
# Coalesced-Interrupt EOI Tracker

This block watches one edge-triggered interrupt line whose consumers must know when a new edge would merge with one that is still in service. After each delivery it records which destinations took the interrupt, and which vector each one got. It then counts the end-of-interrupt (EOI) acknowledgements still owed. While any acknowledgement is outstanding, a new assertion on the line is refused and reported as coalesced. When the count is zero, the assertion is allowed through to the delivery logic, which sits outside this block.

Each destination has a tracking bit and a stored vector. An EOI retires a destination only when its bit is set and the EOI carries the vector stored for that destination. The tracker can be resynchronised from a live per-destination pending-EOI status vector in two ways. The first is an explicit rebuild strobe, which adjusts only the bits that differ. The second is automatic: an EOI that would drive the count below zero triggers a full rebuild.

All event inputs are single-cycle strobes that are taken on the cycle they are high. None of them has back-pressure, so the sender never waits. The status pins are plain levels. When several events arrive in the same cycle, a delivery result has priority, then a rebuild request, then an EOI.

Top module: `eoi_coalesce_tracker`

## Requirements
- R1: In a cycle where `edge_req` is high, `edge_allow` is high if the outstanding count is zero. Otherwise `edge_coalesced` is high. Both outputs are combinational, and both are low when `edge_req` is low.
- R2: A delivery strobe with `dlv_ok`=1 sets the outstanding count, from the next cycle, to the number of ones in `dlv_map` (bit i = destination i).
- R3: A delivery loads the tracking bits with `dlv_map` and stores `dlv_vec` for each destination whose bit is set. A later EOI with that vector retires that destination.
- R4: A delivery strobe with `dlv_ok`=0 sets the count to zero but still loads the tracking bits and vectors as in R3.
- R5: An EOI decrements the count and clears destination `eoi_dest`'s bit only if that bit is set and `eoi_vec` equals the stored vector. Otherwise it has no effect.
- R6: A qualifying EOI that arrives when the count is already zero causes a full rebuild. The bits become `pend_map`, every pending destination stores `rb_vec`, and the count becomes the number of ones in `pend_map`.
- R7: A `rb_req` strobe sets the bits to `pend_map`. Only destinations whose bit goes from clear to set store `rb_vec`. Destinations already set keep their vector. The count becomes the number of ones in `pend_map`.
- R8: In the same cycle, a delivery strobe overrides a rebuild strobe and an EOI, and a rebuild strobe overrides an EOI.
- R9: Reset clears the count and every tracking bit. After reset, `edge_req` is allowed.
- R10: An EOI whose `eoi_dest` is at or above `NUM_DEST` has no effect.
- R11: The outstanding count never exceeds `NUM_DEST`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| edge_req | input | 1 | New assertion seen on the tracked line |
| edge_allow | output | 1 | Assertion may be delivered |
| edge_coalesced | output | 1 | Assertion refused as coalesced |
| dlv_valid | input | 1 | Delivery result strobe |
| dlv_ok | input | 1 | Delivery succeeded |
| dlv_map | input | NUM_DEST | Destinations that accepted the delivery |
| dlv_vec | input | VEC_W | Vector that was delivered |
| eoi_valid | input | 1 | EOI strobe |
| eoi_dest | input | ID_W | Destination sending the EOI |
| eoi_vec | input | VEC_W | Vector being acknowledged |
| rb_req | input | 1 | Rebuild request strobe |
| pend_map | input | NUM_DEST | Live per-destination pending-EOI status |
| rb_vec | input | VEC_W | Vector stored for destinations set during a rebuild |
| out_count | output | CNT_W | Outstanding EOI count |

## Verification
The bench uses the default parameters: 8 destinations, 8-bit vectors and 4-bit destination IDs. Because the ID field is one bit wider than the destination index, IDs 8 to 15 can be driven to exercise the out-of-range case. With only eight destinations, random delivery maps, pending maps and a two-value vector pool often lead to matching EOIs, repeated EOIs and the zero-count underflow rebuild.

// File: rtl/eoi_trk_pkg.sv
package eoi_trk_pkg;

  typedef enum logic [2:0] {
    OP_IDLE      = 3'd0,
    OP_DELIVER   = 3'd1,
    OP_FAIL      = 3'd2,
    OP_REBUILD   = 3'd3,
    OP_EOI       = 3'd4,
    OP_UNDERFLOW = 3'd5
  } trk_op_e;

  function automatic int unsigned ones_in(input logic [63:0] v, input int unsigned n);
    int unsigned c;
    c = 0;
    for (int unsigned i = 0; i < n; i++) begin
      if (v[i]) c++;
    end
    return c;
  endfunction

endpackage

// File: rtl/eoi_op_decode.sv
module eoi_op_decode
  import eoi_trk_pkg::*;
#(
  parameter int NUM_DEST = 8,
  parameter int VEC_W    = 8,
  parameter int ID_W     = 4,
  localparam int IDX_W   = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1
) (
  input  logic                            dlv_valid,
  input  logic                            dlv_ok,
  input  logic                            rb_req,
  input  logic                            eoi_valid,
  input  logic [ID_W-1:0]                 eoi_dest,
  input  logic [VEC_W-1:0]                eoi_vec,
  input  logic [NUM_DEST-1:0]             trk_bits,
  input  logic [NUM_DEST-1:0][VEC_W-1:0]  trk_vecs,
  input  logic                            count_zero,
  output trk_op_e                         op,
  output logic [NUM_DEST-1:0]             eoi_sel
);

  logic             in_range;
  logic [IDX_W-1:0] idx;
  logic             hit;

  always_comb begin
    in_range = (int'(eoi_dest) < NUM_DEST);
    idx      = eoi_dest[IDX_W-1:0];
    hit      = 1'b0;
    if (in_range) begin
      hit = trk_bits[idx] && (trk_vecs[idx] == eoi_vec);
    end
  end

  always_comb begin
    eoi_sel = '0;
    if (in_range) eoi_sel[idx] = 1'b1;
  end

  always_comb begin
    if (dlv_valid) begin
      op = dlv_ok ? OP_DELIVER : OP_FAIL;
    end else if (rb_req) begin
      op = OP_REBUILD;
    end else if (eoi_valid && hit) begin
      op = count_zero ? OP_UNDERFLOW : OP_EOI;
    end else begin
      op = OP_IDLE;
    end
  end

endmodule

// File: rtl/eoi_dest_slot.sv
module eoi_dest_slot
  import eoi_trk_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  trk_op_e          op,
  input  logic             dlv_bit,
  input  logic [VEC_W-1:0] dlv_vec,
  input  logic             pend_bit,
  input  logic [VEC_W-1:0] rb_vec,
  input  logic             eoi_sel,
  output logic             bit_q,
  output logic [VEC_W-1:0] vec_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
      vec_q <= '0;
    end else begin
      unique case (op)
        OP_DELIVER, OP_FAIL: begin
          bit_q <= dlv_bit;
          if (dlv_bit) vec_q <= dlv_vec;
        end
        OP_REBUILD: begin
          bit_q <= pend_bit;
          if (pend_bit && !bit_q) vec_q <= rb_vec;
        end
        OP_UNDERFLOW: begin
          bit_q <= pend_bit;
          if (pend_bit) vec_q <= rb_vec;
        end
        OP_EOI: begin
          if (eoi_sel) bit_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assert_eoi_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_EOI && eoi_sel) |=> !bit_q);

  assert_rebuild_keeps_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_REBUILD && bit_q && pend_bit) |=> $stable(vec_q));

endmodule

// File: rtl/eoi_coalesce_tracker.sv
module eoi_coalesce_tracker
  import eoi_trk_pkg::*;
#(
  parameter int NUM_DEST = 8,
  parameter int VEC_W    = 8,
  parameter int ID_W     = 4,
  localparam int CNT_W   = $clog2(NUM_DEST + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                edge_req,
  output logic                edge_allow,
  output logic                edge_coalesced,
  input  logic                dlv_valid,
  input  logic                dlv_ok,
  input  logic [NUM_DEST-1:0] dlv_map,
  input  logic [VEC_W-1:0]    dlv_vec,
  input  logic                eoi_valid,
  input  logic [ID_W-1:0]     eoi_dest,
  input  logic [VEC_W-1:0]    eoi_vec,
  input  logic                rb_req,
  input  logic [NUM_DEST-1:0] pend_map,
  input  logic [VEC_W-1:0]    rb_vec,
  output logic [CNT_W-1:0]    out_count
);

  trk_op_e                       op;
  logic [NUM_DEST-1:0]           trk_bits;
  logic [NUM_DEST-1:0][VEC_W-1:0] trk_vecs;
  logic [NUM_DEST-1:0]           eoi_sel;
  logic [CNT_W-1:0]              cnt_q;
  logic [CNT_W-1:0]              dlv_ones;
  logic [CNT_W-1:0]              pend_ones;
  logic [63:0]                   dlv_wide;
  logic [63:0]                   pend_wide;

  eoi_op_decode #(
    .NUM_DEST(NUM_DEST), .VEC_W(VEC_W), .ID_W(ID_W)
  ) u_dec (
    .dlv_valid (dlv_valid),
    .dlv_ok    (dlv_ok),
    .rb_req    (rb_req),
    .eoi_valid (eoi_valid),
    .eoi_dest  (eoi_dest),
    .eoi_vec   (eoi_vec),
    .trk_bits  (trk_bits),
    .trk_vecs  (trk_vecs),
    .count_zero(cnt_q == '0),
    .op        (op),
    .eoi_sel   (eoi_sel)
  );

  for (genvar g = 0; g < NUM_DEST; g++) begin : g_slot
    eoi_dest_slot #(.VEC_W(VEC_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .op      (op),
      .dlv_bit (dlv_map[g]),
      .dlv_vec (dlv_vec),
      .pend_bit(pend_map[g]),
      .rb_vec  (rb_vec),
      .eoi_sel (eoi_sel[g]),
      .bit_q   (trk_bits[g]),
      .vec_q   (trk_vecs[g])
    );
  end

  always_comb begin
    dlv_wide  = '0;
    pend_wide = '0;
    dlv_wide[NUM_DEST-1:0]  = dlv_map;
    pend_wide[NUM_DEST-1:0] = pend_map;
    dlv_ones  = CNT_W'(ones_in(dlv_wide, NUM_DEST));
    pend_ones = CNT_W'(ones_in(pend_wide, NUM_DEST));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      unique case (op)
        OP_DELIVER:              cnt_q <= dlv_ones;
        OP_FAIL:                 cnt_q <= '0;
        OP_REBUILD, OP_UNDERFLOW: cnt_q <= pend_ones;
        OP_EOI:                  cnt_q <= cnt_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign edge_allow     = edge_req && (cnt_q == '0);
  assign edge_coalesced = edge_req && (cnt_q != '0);
  assign out_count      = cnt_q;

  assert_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(edge_allow && edge_coalesced));

  assert_count_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_count <= CNT_W'(NUM_DEST));

  assert_fail_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && !dlv_ok) |=> (out_count == '0));

  assert_eoi_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dlv_valid && !rb_req && (out_count != '0)) |=>
      (out_count == $past(out_count)) || (out_count == $past(out_count) - 1'b1));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!dlv_valid && !rb_req && !eoi_valid) |=> $stable(out_count));

endmodule

// File: tb/tb_eoi_coalesce_tracker.sv
module tb_eoi_coalesce_tracker;
  localparam int N  = 8;
  localparam int VW = 8;
  localparam int IW = 4;
  localparam int CW = $clog2(N + 1);

  logic clk = 0, rst_n = 0;
  logic edge_req = 0, edge_allow, edge_coalesced;
  logic dlv_valid = 0, dlv_ok = 0;
  logic [N-1:0] dlv_map = '0;
  logic [VW-1:0] dlv_vec = '0;
  logic eoi_valid = 0;
  logic [IW-1:0] eoi_dest = '0;
  logic [VW-1:0] eoi_vec = '0;
  logic rb_req = 0;
  logic [N-1:0] pend_map = '0;
  logic [VW-1:0] rb_vec = '0;
  logic [CW-1:0] out_count;

  always #10 clk = ~clk;

  eoi_coalesce_tracker #(.NUM_DEST(N), .VEC_W(VW), .ID_W(IW)) dut (.*);

  int checks = 0, fails = 0, cycles = 0;
  int m_cnt = 0;
  bit m_bit[N];
  int m_vec[N];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pend_ones();
    int c = 0;
    for (int i = 0; i < N; i++) if (pend_map[i]) c++;
    return c;
  endfunction

  task automatic model_step();
    if (!rst_n) begin
      m_cnt = 0;
      for (int i = 0; i < N; i++) m_bit[i] = 0;
    end else if (dlv_valid) begin
      int c = 0;
      for (int i = 0; i < N; i++) begin
        m_bit[i] = dlv_map[i];
        if (dlv_map[i]) begin m_vec[i] = dlv_vec; c++; end
      end
      m_cnt = dlv_ok ? c : 0;
    end else if (rb_req) begin
      for (int i = 0; i < N; i++) begin
        if (pend_map[i] && !m_bit[i]) m_vec[i] = rb_vec;
        m_bit[i] = pend_map[i];
      end
      m_cnt = pend_ones();
    end else if (eoi_valid && eoi_dest < N) begin
      if (m_bit[eoi_dest] && m_vec[eoi_dest] == eoi_vec) begin
        if (m_cnt == 0) begin
          for (int i = 0; i < N; i++) begin
            m_bit[i] = pend_map[i];
            if (pend_map[i]) m_vec[i] = rb_vec;
          end
          m_cnt = pend_ones();
        end else begin
          m_bit[eoi_dest] = 0;
          m_cnt--;
        end
      end
    end
  endtask

  // Inputs already driven (after a negedge); compare combinational outputs,
  // advance one edge, update the model, then compare the count.
  task automatic cyc(input string tag);
    #1;
    check(edge_allow == (edge_req && m_cnt == 0), {tag, " R1 allow"}, edge_allow, edge_req && m_cnt == 0);
    check(edge_coalesced == (edge_req && m_cnt != 0), {tag, " R1 coalesced"}, edge_coalesced, edge_req && m_cnt != 0);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(out_count == m_cnt, {tag, " count"}, out_count, m_cnt);
    check(out_count <= N, "R11 range", out_count, N);
    edge_req = 0; dlv_valid = 0; rb_req = 0; eoi_valid = 0;
  endtask

  task automatic deliver(input logic [N-1:0] m, input int v, input bit ok);
    dlv_valid = 1; dlv_map = m; dlv_vec = v; dlv_ok = ok;
  endtask

  task automatic eoi(input int id, input int v);
    eoi_valid = 1; eoi_dest = id; eoi_vec = v;
  endtask

  task automatic expect_cnt(input int e, input string tag);
    check(out_count == e, tag, out_count, e);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); cyc("reset"); cyc("reset");
    rst_n = 1;
    expect_cnt(0, "R9 reset count");
    edge_req = 1; cyc("R9 allow after reset");

    deliver(8'b0001_0110, 8'h41, 1); cyc("R2 deliver");
    expect_cnt(3, "R2 popcount");
    edge_req = 1; cyc("R1 refuse");
    eoi(1, 8'h42); cyc("R5 wrong vec"); expect_cnt(3, "R5 wrong vector ignored");
    eoi(0, 8'h41); cyc("R5 clear bit"); expect_cnt(3, "R5 unset bit ignored");
    eoi(9, 8'h41); cyc("R10"); expect_cnt(3, "R10 out of range id");
    eoi(1, 8'h41); cyc("R3 match"); expect_cnt(2, "R3 stored vector matched");
    eoi(1, 8'h41); cyc("R5 repeat"); expect_cnt(2, "R5 repeat EOI ignored");

    deliver(8'b0000_0001, 8'h50, 1); eoi(2, 8'h41); cyc("R8 dlv>eoi");
    expect_cnt(1, "R8 delivery wins over EOI");
    eoi(2, 8'h41); cyc("R8 bit2 reloaded"); expect_cnt(1, "R8 bit2 cleared by delivery");
    eoi(0, 8'h50); cyc("R5"); expect_cnt(0, "R5 last EOI");
    edge_req = 1; cyc("R1 allow at zero");

    deliver(8'b0000_1100, 8'h60, 0); cyc("R4 fail");
    expect_cnt(0, "R4 failed delivery count");
    pend_map = 8'b0010_0001; rb_vec = 8'h70;
    eoi(3, 8'h60); cyc("R6 underflow"); expect_cnt(2, "R6 rebuilt count");
    eoi(5, 8'h70); cyc("R6 vec"); expect_cnt(1, "R6 rebuilt vector dest5");
    eoi(0, 8'h70); cyc("R6 vec"); expect_cnt(0, "R6 rebuilt vector dest0");

    deliver(8'b0000_0011, 8'h80, 1); cyc("R2"); expect_cnt(2, "R2 two dests");
    pend_map = 8'b0000_0110; rb_vec = 8'h90; rb_req = 1; cyc("R7 rebuild");
    expect_cnt(2, "R7 rebuild count");
    eoi(1, 8'h90); cyc("R7 kept"); expect_cnt(2, "R7 dest1 kept old vector");
    eoi(1, 8'h80); cyc("R7 kept"); expect_cnt(1, "R7 dest1 old vector retires");
    eoi(2, 8'h90); cyc("R7 new"); expect_cnt(0, "R7 dest2 got rebuild vector");

    deliver(8'b0000_0001, 8'hA0, 1); cyc("R2"); expect_cnt(1, "R2 one dest");
    pend_map = 8'b0000_0011; rb_vec = 8'hB0; rb_req = 1; eoi(0, 8'hA0);
    cyc("R8 rb>eoi"); expect_cnt(2, "R8 rebuild wins over EOI");

    rst_n = 0; cyc("R9 reset"); rst_n = 1;
    expect_cnt(0, "R9 reset mid-run");
    eoi(0, 8'hA0); cyc("R9 bits cleared"); expect_cnt(0, "R9 bitmap cleared");

    for (int k = 0; k < 3000; k++) begin
      int r = $urandom_range(0, 9);
      pend_map = $urandom;
      rb_vec = $urandom_range(0, 1) ? 8'h30 : 8'h31;
      edge_req = $urandom_range(0, 1);
      if (r == 0) deliver($urandom, $urandom_range(0, 1) ? 8'h30 : 8'h31, $urandom_range(0, 3) != 0);
      if (r == 1) rb_req = 1;
      if (r >= 2) eoi($urandom_range(0, 9), $urandom_range(0, 1) ? 8'h30 : 8'h31);
      if (r == 2) begin dlv_valid = 1; dlv_map = $urandom; dlv_ok = 1; end
      cyc("R2 R5 R6 R7 R8 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule